// File: doc/BRIEF.md
# Slot-Based Interrupt Router

This block sits between the interrupt pins of devices on a PCI bus and a single interrupt wire going up to the processor. A requester gives the slot number of the device, which of its four interrupt pins (INTA..INTD, coded 0..3) is involved, and a one-cycle strobe marking a change on that pin. From the slot and pin the block works out an internal interrupt number from a fixed per-slot table. Numbers from 32 upward name internal lines 0..31.

Each internal line has one bit in a 32-bit trigger-mode word and one bit in a 32-bit polarity word. When the strobe arrives, the selected line's bits decide the upstream wire. If the trigger-mode bit is set, the wire gives a one-cycle pulse. Otherwise the wire takes the polarity bit and holds it until the next strobe. The mapped number is purely combinational. The upstream wire is registered.

Top module: `irq_slot_router`

## Requirements
- R1: For slot 5, the mapped number is 32 + pin (range 32..35).
- R2: Slot 6 maps to 36 and slot 7 maps to 37, whatever the pin.
- R3: For slots 8 through 12, the mapped number is (slot - 8) + pin + 38. This rotates the pins across the add-in slots.
- R4: Any other slot gives a mapped number equal to the pin code (0..3), untranslated.
- R5: The mapped number follows slot and pin in the same cycle, with no clock edge in between.
- R6: A strobe whose internal line (mapped number - 32) has its trigger-mode bit at 1 drives the upstream wire high for exactly the one cycle after the clock edge that samples the strobe. The wire is low after that unless a new strobe arrives.
- R7: A strobe whose line has its trigger-mode bit at 0 sets the upstream wire, from the next edge on, to that line's polarity bit (1 = high, 0 = low).
- R8: A strobe whose mapped number lies outside 32..63 acts as a line whose trigger-mode and polarity bits are both 0. The upstream wire goes low whatever the configuration words hold.
- R9: With no strobe, the upstream wire keeps its level-mode value even if slot, pin or either configuration word changes.
- R10: While reset is active, and in the first cycle after it, the upstream wire is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 5 | Slot number of the requesting device |
| pin_i | input | 2 | Interrupt pin code, 0..3 |
| event_i | input | 1 | One-cycle strobe: the pin changed state |
| trig_mode_i | input | 32 | Per-line trigger-mode bits (1 = pulse) |
| polarity_i | input | 32 | Per-line polarity bits used in level mode |
| irq_num_o | output | 8 | Mapped interrupt number |
| irq_o | output | 1 | Upstream interrupt wire |

## Verification
The assertions assume the following about the inputs:
- slot, pin and both configuration words are stable and known whenever the strobe is high;
- the strobe is low during reset;
- pin codes never exceed 3.

The stimulus keeps to these assumptions. It changes inputs only on the falling clock edge, raises the strobe for a single cycle per event, and holds it low through reset. It changes configuration words with no strobe only in the phases meant to show that nothing moves without a strobe.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   typedef enum logic [1:0] {
      MAP_PASS   = 2'd0,
      MAP_BRIDGE = 2'd1,
      MAP_FIXED  = 2'd2,
      MAP_ROTATE = 2'd3
   } map_kind_e;

   typedef struct packed {
      logic pulse;
      logic level;
   } line_cfg_t;

endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
   import irq_router_pkg::*;
#(
   parameter int SLOT_W      = 5,
   parameter int PIN_W       = 2,
   parameter int NUM_W       = 8,
   parameter int IRQ_BASE    = 32,
   parameter int SB_SLOT     = 5,
   parameter int GFX_SLOT    = 6,
   parameter int NIC_SLOT    = 7,
   parameter int GFX_LINE    = 4,
   parameter int NIC_LINE    = 5,
   parameter int ADDIN_FIRST = 8,
   parameter int ADDIN_LAST  = 12,
   parameter int ADDIN_LINE0 = 6
) (
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [PIN_W-1:0]  pin_i,
   output map_kind_e         kind_o,
   output logic [NUM_W-1:0]  num_o
);
   localparam logic [NUM_W-1:0] BASE_N   = NUM_W'(IRQ_BASE);
   localparam logic [NUM_W-1:0] GFX_N    = NUM_W'(IRQ_BASE + GFX_LINE);
   localparam logic [NUM_W-1:0] NIC_N    = NUM_W'(IRQ_BASE + NIC_LINE);
   localparam logic [NUM_W-1:0] ROT_OFS  = NUM_W'(IRQ_BASE + ADDIN_LINE0);
   localparam logic [NUM_W-1:0] ROT_FST  = NUM_W'(ADDIN_FIRST);

   generate
      if (NUM_W < SLOT_W) begin : g_bad_num_w
         $error("NUM_W must cover the slot width");
      end
      if (PIN_W < 2) begin : g_bad_pin_w
         $error("PIN_W must hold four pin codes");
      end
      if (ADDIN_LAST < ADDIN_FIRST) begin : g_bad_addin
         $error("add-in slot range is empty");
      end
   endgenerate

   logic [NUM_W-1:0] slot_n;
   logic [NUM_W-1:0] pin_n;
   logic [NUM_W-1:0] pin_mod4;

   assign slot_n   = NUM_W'(slot_i);
   assign pin_n    = NUM_W'(pin_i);
   assign pin_mod4 = NUM_W'(pin_i[1:0]);

   always_comb begin
      kind_o = MAP_PASS;
      if (slot_i == SLOT_W'(SB_SLOT)) begin
         kind_o = MAP_BRIDGE;
      end else if ((slot_i == SLOT_W'(GFX_SLOT)) || (slot_i == SLOT_W'(NIC_SLOT))) begin
         kind_o = MAP_FIXED;
      end else if ((slot_i >= SLOT_W'(ADDIN_FIRST)) && (slot_i <= SLOT_W'(ADDIN_LAST))) begin
         kind_o = MAP_ROTATE;
      end
   end

   always_comb begin
      unique case (kind_o)
         MAP_BRIDGE: num_o = BASE_N + pin_mod4;
         MAP_FIXED:  num_o = (slot_i == SLOT_W'(GFX_SLOT)) ? GFX_N : NIC_N;
         MAP_ROTATE: num_o = slot_n - ROT_FST + pin_n + ROT_OFS;
         default:    num_o = pin_n;
      endcase
   end

endmodule

// File: rtl/irq_line_select.sv
module irq_line_select
   import irq_router_pkg::*;
#(
   parameter int NUM_W    = 8,
   parameter int IRQ_BASE = 32,
   parameter int LINE_CNT = 32
) (
   input  logic [NUM_W-1:0]    num_i,
   input  logic [LINE_CNT-1:0] trig_mode_i,
   input  logic [LINE_CNT-1:0] polarity_i,
   output line_cfg_t           cfg_o
);
   localparam int LINE_W = (LINE_CNT > 1) ? $clog2(LINE_CNT) : 1;
   localparam logic [NUM_W:0] BASE_X = (NUM_W+1)'(IRQ_BASE);
   localparam logic [NUM_W:0] CNT_X  = (NUM_W+1)'(LINE_CNT);

   generate
      if (LINE_CNT < 2) begin : g_bad_cnt
         $error("LINE_CNT must be at least 2");
      end
      if (IRQ_BASE + LINE_CNT > (1 << NUM_W)) begin : g_bad_range
         $error("line range does not fit the number width");
      end
   endgenerate

   logic [NUM_W:0]    ofs;
   logic              in_range;
   logic [LINE_W-1:0] idx;

   assign ofs = {1'b0, num_i} - BASE_X;

   generate
      if (LINE_CNT == (1 << LINE_W)) begin : g_pow2
         assign in_range = ({1'b0, num_i} >= BASE_X) && (ofs[NUM_W:LINE_W] == '0);
      end else begin : g_npow2
         assign in_range = ({1'b0, num_i} >= BASE_X) && (ofs < CNT_X);
      end
   endgenerate

   assign idx = ofs[LINE_W-1:0];

   always_comb begin
      cfg_o = '0;
      if (in_range) begin
         cfg_o.pulse = trig_mode_i[idx];
         cfg_o.level = polarity_i[idx];
      end
   end

endmodule

// File: rtl/irq_upstream_drive.sv
module irq_upstream_drive
   import irq_router_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      event_i,
   input  line_cfg_t cfg_i,
   output logic      irq_o
);
   logic irq_q;
   logic pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else if (event_i) begin
         irq_q   <= cfg_i.pulse ? 1'b1 : cfg_i.level;
         pulse_q <= cfg_i.pulse;
      end else if (pulse_q) begin
         irq_q   <= 1'b0;
         pulse_q <= 1'b0;
      end
   end

   assign irq_o = irq_q;

   AST_EDGE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      event_i && cfg_i.pulse |=> irq_o);  // R6
   AST_EDGE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !event_i && $past(event_i && cfg_i.pulse) |=> !irq_o);  // R6
   AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      event_i && !cfg_i.pulse |=> irq_o == $past(cfg_i.level));  // R7
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !event_i && !$past(event_i && cfg_i.pulse) |=> $stable(irq_o));  // R9

endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
   import irq_router_pkg::*;
#(
   parameter int SLOT_W      = 5,
   parameter int PIN_W       = 2,
   parameter int NUM_W       = 8,
   parameter int IRQ_BASE    = 32,
   parameter int LINE_CNT    = 32,
   parameter int SB_SLOT     = 5,
   parameter int GFX_SLOT    = 6,
   parameter int NIC_SLOT    = 7,
   parameter int GFX_LINE    = 4,
   parameter int NIC_LINE    = 5,
   parameter int ADDIN_FIRST = 8,
   parameter int ADDIN_LAST  = 12,
   parameter int ADDIN_LINE0 = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SLOT_W-1:0]   slot_i,
   input  logic [PIN_W-1:0]    pin_i,
   input  logic                event_i,
   input  logic [LINE_CNT-1:0] trig_mode_i,
   input  logic [LINE_CNT-1:0] polarity_i,
   output logic [NUM_W-1:0]    irq_num_o,
   output logic                irq_o
);
   map_kind_e kind;
   line_cfg_t cfg;

   irq_slot_map #(
      .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W), .IRQ_BASE(IRQ_BASE),
      .SB_SLOT(SB_SLOT), .GFX_SLOT(GFX_SLOT), .NIC_SLOT(NIC_SLOT),
      .GFX_LINE(GFX_LINE), .NIC_LINE(NIC_LINE),
      .ADDIN_FIRST(ADDIN_FIRST), .ADDIN_LAST(ADDIN_LAST), .ADDIN_LINE0(ADDIN_LINE0)
   ) u_map (
      .slot_i(slot_i),
      .pin_i (pin_i),
      .kind_o(kind),
      .num_o (irq_num_o)
   );

   irq_line_select #(
      .NUM_W(NUM_W), .IRQ_BASE(IRQ_BASE), .LINE_CNT(LINE_CNT)
   ) u_sel (
      .num_i      (irq_num_o),
      .trig_mode_i(trig_mode_i),
      .polarity_i (polarity_i),
      .cfg_o      (cfg)
   );

   irq_upstream_drive u_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .event_i(event_i),
      .cfg_i  (cfg),
      .irq_o  (irq_o)
   );

   AST_GFX_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      slot_i == SLOT_W'(GFX_SLOT) |-> irq_num_o == NUM_W'(IRQ_BASE + GFX_LINE));  // R2
   AST_BRIDGE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      kind == MAP_BRIDGE |-> (irq_num_o >= NUM_W'(IRQ_BASE)) && (irq_num_o < NUM_W'(IRQ_BASE + 4)));  // R1
   AST_PASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      kind == MAP_PASS |-> irq_num_o < NUM_W'(4));  // R4
   AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      event_i && (irq_num_o < NUM_W'(IRQ_BASE)) |=> !irq_o);  // R8
   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |=> !irq_o);  // R10

endmodule

// File: tb/irq_slot_router_test.sv
module irq_slot_router_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  slot_i = '0;
   logic [1:0]  pin_i = '0;
   logic        event_i = 1'b0;
   logic [31:0] trig_mode_i = '0;
   logic [31:0] polarity_i = '0;
   logic [7:0]  irq_num_o;
   logic        irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_slot_router uut (
      .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .pin_i(pin_i),
      .event_i(event_i), .trig_mode_i(trig_mode_i), .polarity_i(polarity_i),
      .irq_num_o(irq_num_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (slot=%0d pin=%0d)", req, act, exp, slot_i, pin_i);
      end
   endtask

   function automatic int exp_num(input int s, input int p);
      if (s == 5) return 32 + p;
      if (s == 6) return 36;
      if (s == 7) return 37;
      if (s >= 8 && s <= 12) return (s - 8) + p + 38;
      return p;
   endfunction

   function automatic string num_tag(input int s);
      if (s == 5) return "R1";
      if (s == 6 || s == 7) return "R2";
      if (s >= 8 && s <= 12) return "R3";
      return "R4";
   endfunction

   task automatic fire(input int s, input int p, input logic [31:0] tm, input logic [31:0] pol);
      int n;
      int ln;
      bit ok;
      bit first;
      n  = exp_num(s, p);
      ln = n - 32;
      ok = (ln >= 0) && (ln < 32);
      @(negedge clk);
      slot_i = 5'(s); pin_i = 2'(p); trig_mode_i = tm; polarity_i = pol; event_i = 1'b1;
      @(negedge clk);
      event_i = 1'b0;
      if (ok && tm[ln]) begin
         check("R6 pulse high", int'(irq_o), 1);
         @(negedge clk);
         check("R6 pulse ends", int'(irq_o), 0);
      end else begin
         first = ok ? pol[ln] : 1'b0;
         check(ok ? "R7 level" : "R8 out of range", int'(irq_o), int'(first));
         slot_i = 5'((s + 3) % 32); pin_i = 2'(p + 1);
         trig_mode_i = ~tm; polarity_i = ~pol;
         @(negedge clk);
         check("R9 hold without strobe", int'(irq_o), int'(first));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset low", int'(irq_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after reset", int'(irq_o), 0);

      // R1..R5: exhaustive sweep, compared in the same cycle
      for (int s = 0; s < 32; s++) begin
         for (int p = 0; p < 4; p++) begin
            slot_i = 5'(s); pin_i = 2'(p);
            #1;
            check(num_tag(s), int'(irq_num_o), exp_num(s, p));
            check("R5 same cycle", int'(irq_num_o), exp_num(s, p));
         end
      end

      // R6..R9: several configuration patterns over slots 0..15
      for (int k = 0; k < 4; k++) begin
         logic [31:0] tm;
         logic [31:0] pol;
         case (k)
            0: begin tm = 32'h0000_0000; pol = 32'hFFFF_FFFF; end
            1: begin tm = 32'hFFFF_FFFF; pol = 32'h0000_0000; end
            2: begin tm = 32'h00F0_3C55; pol = 32'h0F0F_A9C3; end
            default: begin tm = 32'hFF0F_C3AA; pol = 32'hF0F0_563C; end
         endcase
         for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 4; p++) begin
               fire(s, p, tm, pol);
            end
         end
      end

      // R6: back-to-back edge strobes keep the wire high, then it drops
      @(negedge clk);
      slot_i = 5'd6; pin_i = 2'd0; trig_mode_i = 32'h0000_0010; polarity_i = '0; event_i = 1'b1;
      @(negedge clk);
      check("R6 first pulse", int'(irq_o), 1);
      @(negedge clk);
      event_i = 1'b0;
      check("R6 second pulse", int'(irq_o), 1);
      @(negedge clk);
      check("R6 after pulses", int'(irq_o), 0);

      // R8: all bits set, passthrough slot still gives low
      fire(0, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule